// File: doc/BRIEF.md
# Three-Pipe Integer Issue Arbiter

The arbiter sits between three integer reservation lanes and three integer pipes (0, 1, 2). Lane n feeds pipe n. In every cycle it looks at the head of each lane, meaning its valid bit, op class, tag and age. It then returns a grant per pipe, and the lane's queue pops its head on that grant. Simple ALU ops may use any pipe.

Three shared long-latency units hang off the pipes, each modelled as a fixed-latency pipeline that carries the op tag:
- The multiplier is fed from pipe 0 and reserves pipes 0 and 1.
- The divider is fed from pipe 2 and reserves pipes 1 and 2.
- The bit-count unit (popcount or leading-zero count) is fed from pipe 2 and reserves pipe 2.

While a reservation is held, only ops of the owning class may enter those pipes. When a unit's last stage is reached, the arbiter returns a one-cycle completion strobe with the op's tag.

A multiply and a divide both need pipe 1, so they can never start together. When both are eligible in the same cycle, the older op wins, judged by the age stamp. A flush input suppresses all grants and completions for one cycle and drops every op in flight, which also frees every reservation.

Top module: `int_issue_arbiter`

## Requirements
- R1: An ALU op (class code 0) at a valid head of any lane is granted whenever that lane's pipe is not reserved and is not taken that cycle by a starting multiply or divide.
- R2: A multiply (class code 1) is granted only from lane 0. While a multiply is in flight, or one is granted in the same cycle, lane 1 receives no grant, and lane 0 grants only further multiplies.
- R3: A divide (class code 2) is granted only from lane 2. While a divide is in flight, or one is granted in the same cycle, lane 1 receives no grant, and lane 2 grants only further divides.
- R4: A bit-count op (class code 3) is granted only from lane 2. While a bit-count op is in flight, lane 2 grants only further bit-count ops.
- R5: A multiply in flight blocks every new divide. A divide in flight blocks every new multiply. A bit-count op in flight blocks every new divide.
- R6: If a multiply and a divide are both eligible in one cycle, the one with the numerically smaller age wins. On equal ages the multiply wins.
- R7: An op granted in cycle c raises its unit's done output for exactly cycle c+LAT, with the op's tag. The default LAT values are 3 for multiply, 12 for divide and 2 for bit-count.
- R8: A unit's reservation holds from the cycle after the grant up to and including the completion cycle of its last op in flight. Ops of the same class may issue back to back meanwhile.
- R9: In a cycle with flush high, all grants and done outputs are 0. From the next cycle on, no op from before the flush is in flight and no reservation remains.
- R10: A head whose class its lane cannot serve is never granted: multiply, divide or bit-count on lane 1; divide or bit-count on lane 0; multiply on lane 2.
- R11: A head with its valid bit low is never granted, and no grant or done output is high while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop all in-flight ops and reservations |
| headValid | input | 3 | Valid head per lane (bit n = lane n) |
| headClass | input | 6 | Class of each head, lane n at bits 2n+1:2n |
| ageLane0 | input | AGE_W | Age stamp of lane 0 head (smaller = older) |
| ageLane2 | input | AGE_W | Age stamp of lane 2 head (smaller = older) |
| tagLane0 | input | TAG_W | Tag of lane 0 head |
| tagLane2 | input | TAG_W | Tag of lane 2 head |
| grant | output | 3 | Issue grant per pipe (bit n = pipe n) |
| mulDone | output | 1 | Multiply completion strobe |
| mulDoneTag | output | TAG_W | Tag of completing multiply |
| divDone | output | 1 | Divide completion strobe |
| divDoneTag | output | TAG_W | Tag of completing divide |
| bcDone | output | 1 | Bit-count completion strobe |
| bcDoneTag | output | TAG_W | Tag of completing bit-count op |

## Verification
The block's only internal state is the set of ops in flight per unit, so a wrong state shows at the ports in one of two ways:
- a grant withheld from, or given to, pipe 1 or a reserved pipe in the very cycle the reservation should differ, or
- a done strobe that fires a cycle early or late, or carries the wrong tag.

A bench model keeps the completion cycle of every op in flight. It compares grants and done strobes every cycle, so a leaked reservation or a lost flush is visible within one cycle of the point where the model and the design part. Directed runs cover each blocking pair, the age tie-break and flush in the middle of a divide. A long mixed run covers overlapping reservations.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2,
    OP_BCNT = 2'd3
  } opClassT;

  // Strobes from the arbitration control to the unit pipelines
  typedef struct packed {
    logic mulGo;
    logic divGo;
    logic bcGo;
    logic flush;
  } issueStrobeT;
endpackage

// File: rtl/issue_unit_pipe.sv
module issue_unit_pipe #(
  parameter int LAT   = 3,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             go,
  input  logic             flush,
  input  logic [TAG_W-1:0] tagIn,
  output logic             busy,
  output logic             done,
  output logic [TAG_W-1:0] doneTag
);
  logic [LAT-1:0]   stageVld;
  logic [TAG_W-1:0] stageTag [LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageVld <= '0;
    end else if (flush) begin
      stageVld <= '0;
    end else begin
      stageVld[0] <= go;
      for (int k = 1; k < LAT; k++) stageVld[k] <= stageVld[k-1];
    end
  end

  always_ff @(posedge clk) begin
    stageTag[0] <= tagIn;
    for (int k = 1; k < LAT; k++) stageTag[k] <= stageTag[k-1];
  end

  assign busy    = |stageVld;
  assign done    = stageVld[LAT-1] && !flush;
  assign doneTag = stageTag[LAT-1];

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !busy);  // R9
  AST_GO_RESERVES: assert property (@(posedge clk) disable iff (!rstN)
    (go && !flush) |=> busy);  // R8
endmodule

// File: rtl/issue_arb_dp.sv
module issue_arb_dp
  import issue_arb_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int MUL_LAT = 3,
  parameter int DIV_LAT = 12,
  parameter int BC_LAT  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  issueStrobeT                strobe,
  input  logic [TAG_W-1:0]           tagLane0,
  input  logic [TAG_W-1:0]           tagLane2,
  output logic [2:0]                 unitBusy,
  output logic [2:0]                 unitDone,
  output logic [2:0][TAG_W-1:0]      unitTag
);
  // unit index: 0 = multiplier, 1 = divider, 2 = bit-count
  localparam int LATS [3] = '{MUL_LAT, DIV_LAT, BC_LAT};

  logic [2:0] unitGo;
  assign unitGo = {strobe.bcGo, strobe.divGo, strobe.mulGo};

  for (genvar u = 0; u < 3; u++) begin : g_unit
    issue_unit_pipe #(.LAT(LATS[u]), .TAG_W(TAG_W)) i_pipe (
      .clk     (clk),
      .rstN    (rstN),
      .go      (unitGo[u]),
      .flush   (strobe.flush),
      .tagIn   ((u == 0) ? tagLane0 : tagLane2),
      .busy    (unitBusy[u]),
      .done    (unitDone[u]),
      .doneTag (unitTag[u])
    );
  end
endmodule

// File: rtl/issue_arb_ctrl.sv
module issue_arb_ctrl
  import issue_arb_pkg::*;
#(
  parameter int AGE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [2:0]       headValid,
  input  logic [5:0]       headClass,
  input  logic [AGE_W-1:0] ageLane0,
  input  logic [AGE_W-1:0] ageLane2,
  input  logic             mulBusy,
  input  logic             divBusy,
  input  logic             bcBusy,
  output logic [2:0]       grant,
  output issueStrobeT      strobe
);
  opClassT cls0, cls1, cls2;
  logic live, mulCand, divCand, mulWin, divWin, bcWin;
  logic alu0, alu1, alu2;

  assign cls0 = opClassT'(headClass[1:0]);
  assign cls1 = opClassT'(headClass[3:2]);
  assign cls2 = opClassT'(headClass[5:4]);

  always_comb begin
    live    = rstN && !flush;
    mulCand = live && headValid[0] && (cls0 == OP_MUL) && !divBusy;
    divCand = live && headValid[2] && (cls2 == OP_DIV) && !mulBusy && !bcBusy;
    mulWin  = mulCand;
    divWin  = divCand;
    if (mulCand && divCand) begin
      if (ageLane2 < ageLane0) mulWin = 1'b0;
      else                     divWin = 1'b0;
    end
    bcWin = live && headValid[2] && (cls2 == OP_BCNT) && !divBusy;
    alu0  = live && headValid[0] && (cls0 == OP_ALU) && !mulBusy;
    alu1  = live && headValid[1] && (cls1 == OP_ALU) && !mulBusy && !divBusy
            && !mulWin && !divWin;
    alu2  = live && headValid[2] && (cls2 == OP_ALU) && !divBusy && !bcBusy;
    grant  = {alu2 | divWin | bcWin, alu1, alu0 | mulWin};
    strobe = '{mulGo: mulWin, divGo: divWin, bcGo: bcWin, flush: flush};
  end

  AST_PIPE1_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (mulBusy || divBusy) |-> !grant[1]);  // R2
  AST_MUL_BLOCKS_DIV: assert property (@(posedge clk) disable iff (!rstN)
    mulBusy |-> !strobe.divGo);  // R5
  AST_DIV_BLOCKS_MUL: assert property (@(posedge clk) disable iff (!rstN)
    divBusy |-> !strobe.mulGo);  // R5
  AST_BCNT_OWNS_PIPE2: assert property (@(posedge clk) disable iff (!rstN)
    (bcBusy && grant[2]) |-> (cls2 == OP_BCNT));  // R4
  AST_DIV_OWNS_PIPE2: assert property (@(posedge clk) disable iff (!rstN)
    (divBusy && grant[2]) |-> (cls2 == OP_DIV));  // R3
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (grant == 3'b000));  // R9
  AST_LANE1_ALU_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    grant[1] |-> (cls1 == OP_ALU));  // R10
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~headValid) == 3'b000);  // R11
endmodule

// File: rtl/int_issue_arbiter.sv
module int_issue_arbiter
  import issue_arb_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int AGE_W   = 5,
  parameter int MUL_LAT = 3,
  parameter int DIV_LAT = 12,
  parameter int BC_LAT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [2:0]       headValid,
  input  logic [5:0]       headClass,
  input  logic [AGE_W-1:0] ageLane0,
  input  logic [AGE_W-1:0] ageLane2,
  input  logic [TAG_W-1:0] tagLane0,
  input  logic [TAG_W-1:0] tagLane2,
  output logic [2:0]       grant,
  output logic             mulDone,
  output logic [TAG_W-1:0] mulDoneTag,
  output logic             divDone,
  output logic [TAG_W-1:0] divDoneTag,
  output logic             bcDone,
  output logic [TAG_W-1:0] bcDoneTag
);
  issueStrobeT          strobe;
  logic [2:0]           unitBusy, unitDone;
  logic [2:0][TAG_W-1:0] unitTag;

  issue_arb_ctrl #(.AGE_W(AGE_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .headValid (headValid),
    .headClass (headClass),
    .ageLane0  (ageLane0),
    .ageLane2  (ageLane2),
    .mulBusy   (unitBusy[0]),
    .divBusy   (unitBusy[1]),
    .bcBusy    (unitBusy[2]),
    .grant     (grant),
    .strobe    (strobe)
  );

  issue_arb_dp #(.TAG_W(TAG_W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT),
                 .BC_LAT(BC_LAT)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tagLane0 (tagLane0),
    .tagLane2 (tagLane2),
    .unitBusy (unitBusy),
    .unitDone (unitDone),
    .unitTag  (unitTag)
  );

  assign mulDone    = unitDone[0];
  assign mulDoneTag = unitTag[0];
  assign divDone    = unitDone[1];
  assign divDoneTag = unitTag[1];
  assign bcDone     = unitDone[2];
  assign bcDoneTag  = unitTag[2];
endmodule

// File: tb/test_int_issue_arbiter.sv
`timescale 1ns/1ps
module test_int_issue_arbiter;
  localparam int TAG_W = 6, AGE_W = 5;
  localparam int LAT_M = 3, LAT_D = 12, LAT_B = 2;
  localparam logic [1:0] ALU = 2'd0, MUL = 2'd1, DIV = 2'd2, BCN = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic [2:0] headValid = '0;
  logic [5:0] headClass = '0;
  logic [AGE_W-1:0] ageLane0 = '0, ageLane2 = '0;
  logic [TAG_W-1:0] tagLane0 = '0, tagLane2 = '0;
  logic [2:0] grant;
  logic mulDone, divDone, bcDone;
  logic [TAG_W-1:0] mulDoneTag, divDoneTag, bcDoneTag;

  always #2.5 clk = ~clk;

  int_issue_arbiter #(.TAG_W(TAG_W), .AGE_W(AGE_W), .MUL_LAT(LAT_M),
                      .DIV_LAT(LAT_D), .BC_LAT(LAT_B)) i_int_issue_arbiter (
    .clk(clk), .rstN(rstN), .flush(flush), .headValid(headValid),
    .headClass(headClass), .ageLane0(ageLane0), .ageLane2(ageLane2),
    .tagLane0(tagLane0), .tagLane2(tagLane2), .grant(grant),
    .mulDone(mulDone), .mulDoneTag(mulDoneTag), .divDone(divDone),
    .divDoneTag(divDoneTag), .bcDone(bcDone), .bcDoneTag(bcDoneTag));

  int checks = 0, fails = 0, cyc = 0;
  // reference: completion cycle and tag of every op in flight, per unit
  int mCyc[$], mTag[$], dCyc[$], dTag[$], bCyc[$], bTag[$];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic checkDone(input string what, ref int q[$], ref int t[$],
                           input logic dn, input logic [TAG_W-1:0] tg, input logic fl);
    logic expDn;
    expDn = rstN && !fl && q.size() > 0 && q[0] == cyc;
    check("R7", what, int'(dn), int'(expDn));
    if (expDn) check("R7", {what, " tag"}, int'(tg), t[0]);
  endtask

  task automatic step(input logic [2:0] v, input logic [1:0] c0, input logic [1:0] c1,
                      input logic [1:0] c2, input int a0, input int a2, input int t0,
                      input int t2, input logic fl, input string req);
    logic mB, dB, bB, mC, dC, bC, g0, g1, g2;
    @(negedge clk);
    headValid = v; headClass = {c2, c1, c0};
    ageLane0 = AGE_W'(a0); ageLane2 = AGE_W'(a2);
    tagLane0 = TAG_W'(t0); tagLane2 = TAG_W'(t2); flush = fl;
    #1;
    while (mCyc.size() > 0 && mCyc[0] < cyc) begin void'(mCyc.pop_front()); void'(mTag.pop_front()); end
    while (dCyc.size() > 0 && dCyc[0] < cyc) begin void'(dCyc.pop_front()); void'(dTag.pop_front()); end
    while (bCyc.size() > 0 && bCyc[0] < cyc) begin void'(bCyc.pop_front()); void'(bTag.pop_front()); end
    mB = mCyc.size() > 0; dB = dCyc.size() > 0; bB = bCyc.size() > 0;
    mC = v[0] && c0 == MUL && !dB;
    dC = v[2] && c2 == DIV && !mB && !bB;
    if (mC && dC) begin
      if (a2 < a0) mC = 1'b0; else dC = 1'b0;
    end
    bC = v[2] && c2 == BCN && !dB;
    g0 = mC || (v[0] && c0 == ALU && !mB);
    g1 = v[1] && c1 == ALU && !mB && !dB && !mC && !dC;
    g2 = dC || bC || (v[2] && c2 == ALU && !dB && !bB);
    if (!rstN || fl) begin g0 = 0; g1 = 0; g2 = 0; mC = 0; dC = 0; bC = 0; end
    check(req, "grant", int'(grant), int'({g2, g1, g0}));
    checkDone("mulDone", mCyc, mTag, mulDone, mulDoneTag, fl);
    checkDone("divDone", dCyc, dTag, divDone, divDoneTag, fl);
    checkDone("bcDone", bCyc, bTag, bcDone, bcDoneTag, fl);
    @(posedge clk);
    if (fl) begin
      mCyc.delete(); mTag.delete(); dCyc.delete(); dTag.delete(); bCyc.delete(); bTag.delete();
    end else begin
      if (mC) begin mCyc.push_back(cyc + LAT_M); mTag.push_back(t0); end
      if (dC) begin dCyc.push_back(cyc + LAT_D); dTag.push_back(t2); end
      if (bC) begin bCyc.push_back(cyc + LAT_B); bTag.push_back(t2); end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'b000, ALU, ALU, ALU, 0, 0, 0, 0, 1'b0, "R11 idle");
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset holds every grant and done low
    for (int i = 0; i < 3; i++) step(3'b111, ALU, ALU, ALU, 0, 0, 1, 2, 1'b0, "R11 reset");
    @(negedge clk); rstN = 1'b1;
    step(3'b111, ALU, ALU, ALU, 0, 0, 1, 2, 1'b0, "R1 all alu");
    step(3'b000, ALU, ALU, ALU, 0, 0, 1, 2, 1'b0, "R11 invalid heads");
    step(3'b101, ALU, MUL, ALU, 0, 0, 1, 2, 1'b0, "R11 partial valid");
    // R2: multiply start takes pipe 1; back-to-back; lane 0 alu held
    step(3'b111, MUL, ALU, ALU, 4, 0, 5, 2, 1'b0, "R2 mul start");
    step(3'b111, ALU, ALU, DIV, 0, 0, 6, 7, 1'b0, "R5 mul blocks div");
    step(3'b111, MUL, ALU, BCN, 0, 0, 8, 9, 1'b0, "R8 mul back to back");
    step(3'b111, ALU, ALU, ALU, 0, 0, 3, 4, 1'b0, "R2 mul reservation");
    idle(6);
    step(3'b111, ALU, ALU, ALU, 0, 0, 0, 0, 1'b0, "R8 reservation released");
    // R3: divide start, then pipe 2 only divides
    step(3'b111, ALU, ALU, DIV, 0, 0, 1, 11, 1'b0, "R3 div start");
    step(3'b111, MUL, ALU, ALU, 0, 0, 12, 13, 1'b0, "R5 div blocks mul");
    step(3'b111, ALU, ALU, BCN, 0, 0, 14, 15, 1'b0, "R3 div blocks bcnt");
    step(3'b111, ALU, ALU, DIV, 0, 0, 16, 17, 1'b0, "R8 div back to back");
    idle(14);
    // R4: bit-count reserves pipe 2
    step(3'b111, ALU, ALU, BCN, 0, 0, 1, 21, 1'b0, "R4 bcnt start");
    step(3'b111, ALU, ALU, DIV, 0, 0, 1, 22, 1'b0, "R5 bcnt blocks div");
    step(3'b111, ALU, ALU, ALU, 0, 0, 1, 23, 1'b0, "R4 bcnt blocks alu");
    step(3'b111, MUL, ALU, BCN, 0, 0, 24, 25, 1'b0, "R4 bcnt again with mul");
    idle(6);
    // R6: simultaneous multiply and divide
    step(3'b111, MUL, ALU, DIV, 7, 3, 30, 31, 1'b0, "R6 older div wins");
    idle(14);
    step(3'b111, MUL, ALU, DIV, 2, 9, 32, 33, 1'b0, "R6 older mul wins");
    idle(5);
    step(3'b101, MUL, ALU, DIV, 5, 5, 34, 35, 1'b0, "R6 tie to mul");
    idle(5);
    // R10: classes on lanes that cannot serve them
    step(3'b111, DIV, MUL, MUL, 0, 0, 1, 2, 1'b0, "R10 wrong lane a");
    step(3'b111, BCN, DIV, ALU, 0, 0, 1, 2, 1'b0, "R10 wrong lane b");
    step(3'b010, ALU, BCN, ALU, 0, 0, 1, 2, 1'b0, "R10 wrong lane c");
    // R9: flush in the middle of a divide
    step(3'b100, ALU, ALU, DIV, 0, 0, 1, 40, 1'b0, "R9 div before flush");
    step(3'b111, MUL, ALU, ALU, 0, 0, 41, 2, 1'b1, "R9 flush cycle");
    step(3'b111, MUL, ALU, ALU, 0, 0, 42, 2, 1'b0, "R9 after flush");
    idle(5);
    step(3'b001, MUL, ALU, ALU, 0, 0, 43, 2, 1'b0, "R9 mul before flush");
    idle(2);
    step(3'b000, ALU, ALU, ALU, 0, 0, 0, 0, 1'b1, "R9 flush hides done");
    step(3'b111, ALU, ALU, ALU, 0, 0, 0, 0, 1'b0, "R1 after flush");
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] r0, r1, r2;
      r0 = ($urandom % 3 == 0) ? MUL : (($urandom % 8 == 0) ? DIV : ALU);
      r1 = ($urandom % 10 == 0) ? 2'($urandom) : ALU;
      r2 = 2'($urandom);
      step(3'($urandom), r0, r1, r2, int'($urandom % 32), int'($urandom % 32),
           int'($urandom % 64), int'($urandom % 64), ($urandom % 40) == 0, "R1 R5 mixed");
    end
    idle(16);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule